// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Comparator

This debug block watches every bus cycle issued by the CPU or by the DMA engine. It raises one break request toward the exception logic when a programmed condition matches. Channels A and B each compare the cycle address against a programmed address, skipping the bit positions that the address mask sets. On CPU cycles each channel also compares the address-space ID. Each channel qualifies the cycle by master, access kind and direction. Channel B can in addition compare the data word under a mask, but only on data accesses.

A channel programmed for instruction fetch breaks either before or after the fetched instruction runs, as its control bit selects. Fetches that are never executed do not count. A fetch break on a delay-slot instruction is held back and taken in front of the next instruction that can accept it. The four match flags are sticky, one per channel for CPU cycles and one for DMA cycles, and software clears them. Matches that come close together produce a single request, and the request carries a type code.

The block is configured through a simple write port. The register indices are: 0..3 for channel A (address, ASID, mask, condition), 4..7 for channel B in the same layout, 8 for the channel B data value, 9 for the channel B data mask, and 10 for flag clearing.

Top module: `dbg_brk_unit`

## Requirements
- R1: A channel matches only when every address bit whose mask bit is 0 equals the programmed address; mask bits at 1 are not compared. On CPU cycles (bus_dma=0) bus_asid must also equal the programmed ASID. DMA cycles skip the ASID compare.
- R2: The condition register holds three 2-bit groups: master in bits [1:0] (bit0 CPU, bit1 DMA), access kind in bits [3:2] (bit2 fetch, bit3 data), direction in bits [5:4] (bit4 read, bit5 write). A cycle matches only if the bit for its master, kind and direction is set in each group, so a group of 00 disables the channel.
- R3: Channel B also requires ((bus_data ^ data value) & ~data mask) == 0, and only on data accesses. A data mask bit of 1 makes that bit don't-care.
- R4: match_flags bit 2*ch is set by a CPU-cycle match of channel ch (A=0, B=1), and bit 2*ch+1 is set by a DMA-cycle match. A flag stays set until a write to index 10 with a 0 in its bit position. Writing 1 leaves it unchanged, and a new match in the same cycle wins over the clear.
- R5: A data-access match or a pre-execution fetch match raises brk_req on the clock edge that samples it. brk_req holds until brk_ack is high at an edge, unless a new request fires at that same edge.
- R6: While brk_req is high, further matches do not change brk_type, although their flags are set. Channels matching in the same cycle give one request and set both flags.
- R7: Condition bit 6 selects post-execution for a fetch break. A post-execution fetch match raises brk_req one edge later than a pre-execution match (bit 6 = 0) would.
- R8: A fetch cycle with bus_exec=0 (an overrun fetch) never matches: it sets no flag and raises no request.
- R9: A fetch match with bus_dslot=1 sets its flag but raises no request. The request is raised at the edge of the next cycle that is a valid, executed fetch with bus_dslot=0, with type 00.
- R10: brk_type codes are 00 fetch before execution, 01 fetch after execution, 10 data access, and 11 data access flagged by bus_io (on-chip I/O or TLB-load). When sources fire together, a data access wins over a post-execution fetch, which wins over a pre-execution fetch.
- R11: After reset all configuration registers are 0, so every channel is disabled. match_flags, brk_req and brk_type are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | CFG_DW | Configuration write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | AW | Cycle address |
| bus_asid | input | IDW | Address-space ID of the cycle |
| bus_data | input | DW | Cycle data |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| bus_data_acc | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_io | input | 1 | Data access to on-chip I/O or TLB load |
| bus_exec | input | 1 | Fetched instruction is confirmed to execute |
| bus_dslot | input | 1 | Fetched instruction sits in a delay slot |
| brk_ack | input | 1 | Acknowledge, clears brk_req |
| brk_req | output | 1 | Break request, held until acknowledged |
| brk_type | output | 2 | Break type code |
| match_flags | output | 4 | Sticky match flags {B DMA, B CPU, A DMA, A CPU} |

## Verification
A data or pre-execution fetch match appears on brk_req and match_flags one edge after the cycle is driven. A post-execution fetch appears one edge later still. A deferred delay-slot break appears at the edge that samples the next accepting fetch. Inputs change on the falling edge, and every check samples on the falling edge that follows the edge where the result is due. For the post-execution case the bench first checks that brk_req is still low after the first edge, then high after the second. Persistence checks (held request, frozen type, sticky flags) sample again after several idle edges.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

  localparam int NCH    = 2;
  localparam int NFLAG  = 2 * NCH;
  localparam int REG_AW = 4;

  // per-channel register offsets, channel base = ch * 4
  localparam int OFF_ADDR = 0;
  localparam int OFF_ASID = 1;
  localparam int OFF_MASK = 2;
  localparam int OFF_COND = 3;

  localparam logic [REG_AW-1:0] IDX_BDATA = 4'd8;
  localparam logic [REG_AW-1:0] IDX_BMASK = 4'd9;
  localparam logic [REG_AW-1:0] IDX_CLR   = 4'd10;

  typedef enum logic [1:0] {
    BRK_FETCH_PRE  = 2'b00,
    BRK_FETCH_POST = 2'b01,
    BRK_DATA       = 2'b10,
    BRK_IO         = 2'b11
  } brk_kind_e;

  // condition word: post[6] dir[5:4] kind[3:2] mst[1:0]
  typedef struct packed {
    logic       post;
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] mst;
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  function automatic logic [REG_AW-1:0] reg_idx(input int ch, input int off);
    return REG_AW'(ch * 4 + off);
  endfunction

endpackage

// File: rtl/dbg_brk_regs.sv
module dbg_brk_regs
  import dbg_brk_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDW    = 8,
  parameter int DW     = 32,
  parameter int CFG_DW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [REG_AW-1:0]      cfg_addr,
  input  logic [CFG_DW-1:0]      cfg_wdata,
  input  logic                   bus_dma,
  input  logic [NCH-1:0]         ch_hit,
  output logic [AW-1:0]          ch_addr  [NCH],
  output logic [IDW-1:0]         ch_asid  [NCH],
  output logic [AW-1:0]          ch_amask [NCH],
  output cond_t                  ch_cond  [NCH],
  output logic [DW-1:0]          b_data,
  output logic [DW-1:0]          b_dmask,
  output logic [NFLAG-1:0]       flags_q
);

  logic             clr_wr;
  logic [NFLAG-1:0] set_vec;

  assign clr_wr = cfg_we && (cfg_addr == IDX_CLR);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_addr[ch]  <= '0;
        ch_asid[ch]  <= '0;
        ch_amask[ch] <= '0;
        ch_cond[ch]  <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == reg_idx(ch, OFF_ADDR)) ch_addr[ch]  <= cfg_wdata[AW-1:0];
        if (cfg_addr == reg_idx(ch, OFF_ASID)) ch_asid[ch]  <= cfg_wdata[IDW-1:0];
        if (cfg_addr == reg_idx(ch, OFF_MASK)) ch_amask[ch] <= cfg_wdata[AW-1:0];
        if (cfg_addr == reg_idx(ch, OFF_COND)) ch_cond[ch]  <= cond_t'(cfg_wdata[COND_W-1:0]);
      end
    end
    assign set_vec[2*ch]   = ch_hit[ch] & ~bus_dma;
    assign set_vec[2*ch+1] = ch_hit[ch] &  bus_dma;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_data  <= '0;
      b_dmask <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == IDX_BDATA) b_data  <= cfg_wdata[DW-1:0];
      if (cfg_addr == IDX_BMASK) b_dmask <= cfg_wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (clr_wr ? (flags_q & cfg_wdata[NFLAG-1:0]) : flags_q) | set_vec;
  end

  // R4: without a clear write no flag ever drops
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> (($past(flags_q) & ~flags_q) == '0));

  // R4: a match always leaves its flag set
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/dbg_brk_chan.sv
module dbg_brk_chan
  import dbg_brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IDW      = 8,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   c_addr,
  input  logic [IDW-1:0]  c_asid,
  input  logic [AW-1:0]   c_amask,
  input  cond_t           c_cond,
  input  logic [DW-1:0]   c_data,
  input  logic [DW-1:0]   c_dmask,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic [IDW-1:0]  bus_asid,
  input  logic [DW-1:0]   bus_data,
  input  logic            bus_dma,
  input  logic            bus_data_acc,
  input  logic            bus_write,
  input  logic            bus_exec,
  output logic            hit,
  output logic            hit_fetch,
  output logic            post_sel
);

  logic addr_ok, asid_ok, mst_ok, kind_ok, dir_ok, exec_ok, data_ok;

  assign addr_ok = ((bus_addr ^ c_addr) & ~c_amask) == '0;
  assign asid_ok = bus_dma || (bus_asid == c_asid);
  assign mst_ok  = bus_dma      ? c_cond.mst[1]  : c_cond.mst[0];
  assign kind_ok = bus_data_acc ? c_cond.kind[1] : c_cond.kind[0];
  assign dir_ok  = bus_write    ? c_cond.dir[1]  : c_cond.dir[0];
  assign exec_ok = bus_data_acc || bus_exec;

  if (HAS_DATA) begin : g_data
    assign data_ok = !bus_data_acc || (((bus_data ^ c_data) & ~c_dmask) == '0);
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{c_data, c_dmask, bus_data};
    assign data_ok     = 1'b1;
  end

  assign hit       = bus_valid && addr_ok && asid_ok && mst_ok && kind_ok
                     && dir_ok && exec_ok && data_ok;
  assign hit_fetch = hit && !bus_data_acc;
  assign post_sel  = c_cond.post;

  // R8: an overrun fetch never produces a hit
  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_data_acc && !bus_exec) |-> !hit);

  // R2: a zero qualifier group keeps the channel silent
  p_group_off_r2: assert property (@(posedge clk) disable iff (rst)
    ((c_cond.mst == 2'b00) || (c_cond.kind == 2'b00) || (c_cond.dir == 2'b00)) |-> !hit);

endmodule

// File: rtl/dbg_brk_merge.sv
module dbg_brk_merge
  import dbg_brk_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hit,
  input  logic [N-1:0]  hit_fetch,
  input  logic [N-1:0]  post_sel,
  input  logic          bus_valid,
  input  logic          bus_data_acc,
  input  logic          bus_exec,
  input  logic          bus_dslot,
  input  logic          bus_io,
  input  logic          brk_ack,
  output logic          brk_req,
  output brk_kind_e     brk_type
);

  logic      data_now, pre_now, post_now, ds_now, accept, rel_ds, fire;
  logic      post_pend_q, ds_pend_q;
  brk_kind_e type_n;

  assign data_now = |(hit & ~hit_fetch);
  assign pre_now  = (|(hit_fetch & ~post_sel)) && !bus_dslot;
  assign post_now = (|(hit_fetch &  post_sel)) && !bus_dslot;
  assign ds_now   = (|hit_fetch) && bus_dslot;
  assign accept   = bus_valid && !bus_data_acc && bus_exec && !bus_dslot;
  assign rel_ds   = ds_pend_q && accept;
  assign fire     = data_now || post_pend_q || pre_now || rel_ds;

  always_comb begin
    if (data_now)         type_n = bus_io ? BRK_IO : BRK_DATA;
    else if (post_pend_q) type_n = BRK_FETCH_POST;
    else                  type_n = BRK_FETCH_PRE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_pend_q <= 1'b0;
      ds_pend_q   <= 1'b0;
      brk_req     <= 1'b0;
      brk_type    <= BRK_FETCH_PRE;
    end else begin
      post_pend_q <= post_now;
      ds_pend_q   <= ds_now || (ds_pend_q && !accept);
      brk_req     <= fire || (brk_req && !brk_ack);
      if (fire && (!brk_req || brk_ack)) brk_type <= type_n;
    end
  end

  // R5: request holds until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (brk_req && !brk_ack) |=> brk_req);

  // R5: acknowledge drops the request when nothing new fires
  p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (brk_req && brk_ack && !fire) |=> !brk_req);

  // R6: type frozen while a request is outstanding
  p_type_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (brk_req && !brk_ack) |=> $stable(brk_type));

  // R7: a post-execution match fires on the following cycle
  p_post_next_r7: assert property (@(posedge clk) disable iff (rst)
    post_now |=> fire);

  // R9: a delay-slot fetch match alone raises nothing at its own edge
  p_dslot_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ds_now && !brk_req && !data_now && !post_pend_q) |=> !brk_req);

endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
  import dbg_brk_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDW    = 8,
  parameter int DW     = 32,
  parameter int CFG_DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               bus_valid,
  input  logic [AW-1:0]      bus_addr,
  input  logic [IDW-1:0]     bus_asid,
  input  logic [DW-1:0]      bus_data,
  input  logic               bus_dma,
  input  logic               bus_data_acc,
  input  logic               bus_write,
  input  logic               bus_io,
  input  logic               bus_exec,
  input  logic               bus_dslot,
  input  logic               brk_ack,
  output logic               brk_req,
  output logic [1:0]         brk_type,
  output logic [3:0]         match_flags
);

  logic [AW-1:0]    ch_addr  [NCH];
  logic [IDW-1:0]   ch_asid  [NCH];
  logic [AW-1:0]    ch_amask [NCH];
  cond_t            ch_cond  [NCH];
  logic [DW-1:0]    b_data, b_dmask;
  logic [NCH-1:0]   hit, hit_fetch, post_sel;
  logic [NFLAG-1:0] flags_q;
  brk_kind_e        type_q;

  dbg_brk_regs #(.AW(AW), .IDW(IDW), .DW(DW), .CFG_DW(CFG_DW)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_dma(bus_dma), .ch_hit(hit),
    .ch_addr(ch_addr), .ch_asid(ch_asid), .ch_amask(ch_amask),
    .ch_cond(ch_cond), .b_data(b_data), .b_dmask(b_dmask), .flags_q(flags_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dbg_brk_chan #(.AW(AW), .IDW(IDW), .DW(DW), .HAS_DATA(ch == NCH - 1)) i_chan (
      .clk(clk), .rst(rst),
      .c_addr(ch_addr[ch]), .c_asid(ch_asid[ch]), .c_amask(ch_amask[ch]),
      .c_cond(ch_cond[ch]), .c_data(b_data), .c_dmask(b_dmask),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
      .bus_data(bus_data), .bus_dma(bus_dma), .bus_data_acc(bus_data_acc),
      .bus_write(bus_write), .bus_exec(bus_exec),
      .hit(hit[ch]), .hit_fetch(hit_fetch[ch]), .post_sel(post_sel[ch])
    );
  end

  dbg_brk_merge #(.N(NCH)) i_merge (
    .clk(clk), .rst(rst), .hit(hit), .hit_fetch(hit_fetch), .post_sel(post_sel),
    .bus_valid(bus_valid), .bus_data_acc(bus_data_acc), .bus_exec(bus_exec),
    .bus_dslot(bus_dslot), .bus_io(bus_io), .brk_ack(brk_ack),
    .brk_req(brk_req), .brk_type(type_q)
  );

  assign brk_type    = type_q;
  assign match_flags = flags_q;

  // R11: reset leaves no request behind
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!brk_req && (match_flags == '0)));

endmodule

// File: tb/test_dbg_brk_unit.sv
`timescale 1ns/1ps
module test_dbg_brk_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0, bus_dma = 1'b0, bus_data_acc = 1'b0;
  logic        bus_write = 1'b0, bus_io = 1'b0, bus_exec = 1'b0, bus_dslot = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [7:0]  bus_asid = '0;
  logic        brk_ack = 1'b0;
  logic        brk_req;
  logic [1:0]  brk_type;
  logic [3:0]  match_flags;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_brk_unit i_dbg_brk_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_data(bus_data),
    .bus_dma(bus_dma), .bus_data_acc(bus_data_acc), .bus_write(bus_write), .bus_io(bus_io),
    .bus_exec(bus_exec), .bus_dslot(bus_dslot), .brk_ack(brk_ack),
    .brk_req(brk_req), .brk_type(brk_type), .match_flags(match_flags)
  );

  typedef struct packed {
    logic        dma, dacc, wr, io, exec;
    logic [31:0] addr;
    logic [7:0]  asid;
    logic [31:0] data;
    logic        req;
    logic [1:0]  typ;
    logic [3:0]  flg;
  } vec_t;

  // A: 0x1000 mask 0xF asid 5, CPU fetch read, pre. B: 0x2000 asid 5, any master data write, data 0x....AB..
  localparam vec_t VECS [12] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h1004, 8'd5, 32'h0,        1'b1, 2'b00, 4'h1}, // R1 hit under mask
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h1004, 8'd6, 32'h0,        1'b0, 2'b00, 4'h0}, // R1 asid mismatch
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h1014, 8'd5, 32'h0,        1'b0, 2'b00, 4'h0}, // R1 unmasked bit differs
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h1004, 8'd5, 32'h0,        1'b0, 2'b00, 4'h0}, // R8 overrun fetch
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 32'h1004, 8'd5, 32'h0,        1'b0, 2'b00, 4'h0}, // R2 master excluded
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 32'h2000, 8'd5, 32'h1234AB56, 1'b1, 2'b10, 4'h4}, // R3 data hit CPU
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 32'h2000, 8'd0, 32'h9999AB00, 1'b1, 2'b10, 4'h8}, // R4 DMA flag, asid skipped
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 32'h2000, 8'd5, 32'h1234AC56, 1'b0, 2'b00, 4'h0}, // R3 data mismatch
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h2000, 8'd5, 32'h1234AB56, 1'b0, 2'b00, 4'h0}, // R2 direction excluded
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 32'h2000, 8'd5, 32'h0000AB00, 1'b1, 2'b11, 4'h4}, // R10 io type
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h1004, 8'd5, 32'h0,        1'b0, 2'b00, 4'h0}, // R2 kind excluded
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 32'h2000, 8'd3, 32'h0000AC00, 1'b0, 2'b00, 4'h0}  // R3 DMA data mismatch
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic bus(input logic dma, dacc, w, io, ex, ds,
                     input logic [31:0] a, input logic [7:0] id, input logic [31:0] d);
    bus_valid = 1'b1; bus_dma = dma; bus_data_acc = dacc; bus_write = w;
    bus_io = io; bus_exec = ex; bus_dslot = ds; bus_addr = a; bus_asid = id; bus_data = d;
  endtask

  task automatic idle();
    bus_valid = 1'b0; bus_exec = 1'b0; bus_dslot = 1'b0; bus_io = 1'b0;
  endtask

  task automatic ack_clear();
    brk_ack = 1'b1; cfg_we = 1'b1; cfg_addr = 4'd10; cfg_wdata = '0;
    cyc();
    brk_ack = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic base_cfg();
    wr(4'd0, 32'h1000); wr(4'd1, 32'd5); wr(4'd2, 32'hF); wr(4'd3, 32'h15);
    wr(4'd4, 32'h2000); wr(4'd5, 32'd5); wr(4'd6, 32'h0); wr(4'd7, 32'h2B);
    wr(4'd8, 32'h0000AB00); wr(4'd9, 32'hFFFF00FF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst = 1'b0;
    check(brk_req, 0, "R11 req after reset");
    check(brk_type, 0, "R11 type after reset");
    check(match_flags, 0, "R11 flags after reset");
    bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 8'd0, 32'h0);
    cyc(); idle(); cyc();
    check(brk_req, 0, "R11 zero config silent");
    check(match_flags, 0, "R11 zero config no flag");

    base_cfg();
    foreach (VECS[i]) begin
      bus(VECS[i].dma, VECS[i].dacc, VECS[i].wr, VECS[i].io, VECS[i].exec, 1'b0,
          VECS[i].addr, VECS[i].asid, VECS[i].data);
      cyc(); idle(); cyc();
      check(brk_req, VECS[i].req, $sformatf("R1/R2/R3 vec%0d req", i));
      if (VECS[i].req) check(brk_type, VECS[i].typ, $sformatf("R10 vec%0d type", i));
      check(match_flags, VECS[i].flg, $sformatf("R4 vec%0d flags", i));
      ack_clear();
    end

    // R7: post-execution fetch is one edge later
    wr(4'd3, 32'h55);
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1008, 8'd5, 32'h0);
    cyc(); idle();
    check(brk_req, 0, "R7 post not yet");
    cyc();
    check(brk_req, 1, "R7 post raised");
    check(brk_type, 1, "R7 post type");
    ack_clear();

    // R10: data beats post when both fire together
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1008, 8'd5, 32'h0);
    cyc();
    bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2000, 8'd5, 32'h0000AB00);
    cyc(); idle();
    check(brk_req, 1, "R10 priority req");
    check(brk_type, 2, "R10 data over post");
    check(match_flags, 5, "R10 both flags");
    cyc(); ack_clear();

    // R9: delay-slot fetch deferred to next accepting fetch
    wr(4'd3, 32'h15);
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1004, 8'd5, 32'h0);
    cyc(); idle();
    check(brk_req, 0, "R9 no req on slot");
    check(match_flags, 1, "R9 flag on slot");
    cyc();
    check(brk_req, 0, "R9 still deferred");
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h3000, 8'd5, 32'h0);
    cyc(); idle();
    check(brk_req, 1, "R9 released");
    check(brk_type, 0, "R9 type pre");
    ack_clear();

    // R5/R6: hold, merge, frozen type, ack vs new fire
    bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2000, 8'd5, 32'h0000AB00);
    cyc();
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1004, 8'd5, 32'h0);
    cyc(); idle();
    check(brk_req, 1, "R6 merged req");
    check(brk_type, 2, "R6 type frozen");
    check(match_flags, 5, "R6 second flag set");
    repeat (3) cyc();
    check(brk_req, 1, "R5 held");
    brk_ack = 1'b1;
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1004, 8'd5, 32'h0);
    cyc(); idle(); brk_ack = 1'b0;
    check(brk_req, 1, "R5 new fire beats ack");
    check(brk_type, 0, "R5 new type");
    brk_ack = 1'b1; cyc(); brk_ack = 1'b0;
    check(brk_req, 0, "R5 ack drops");
    ack_clear();

    // R4: write 1 keeps, write 0 clears
    bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1004, 8'd5, 32'h0);
    cyc(); idle();
    wr(4'd10, 32'hF);
    check(match_flags, 1, "R4 write one keeps");
    wr(4'd10, 32'hE);
    check(match_flags, 0, "R4 write zero clears");
    ack_clear();

    // R6: both channels in one cycle
    wr(4'd2, 32'hFFFFFFFF); wr(4'd3, 32'h3F);
    bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2000, 8'd5, 32'h0000AB00);
    cyc(); idle();
    check(brk_req, 1, "R6 dual req");
    check(match_flags, 5, "R6 dual flags");
    check(brk_type, 2, "R6 dual type");
    ack_clear();

    // R2: master group 00 disables both channels
    wr(4'd3, 32'h3C); wr(4'd7, 32'h28);
    bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2000, 8'd5, 32'h0000AB00);
    cyc(); idle(); cyc();
    check(brk_req, 0, "R2 group 00 req");
    check(match_flags, 0, "R2 group 00 flags");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule